// File: doc/BRIEF.md
# Firmware Region Write Guard Register

This block is a single 8-bit configuration register that decides whether the boot-firmware region of a flash device may be written. Software reaches it through a plain configuration read/write port. Only one register offset is decoded. Software sets a write-enable bit to open the region for writes.

Two bits can only be set. Once set, they stay set until reset:
- A lock bit. While it is set, any attempt to turn write-enable on raises a one-cycle management interrupt request, so a handler can step in.
- A management-only bit. While it is set, the region is writable only for accesses that are marked as coming from system-management mode.

The register also holds a 2-bit read-configuration field and a read-only top-swap status bit, which mirrors a strap input.

Top module: `fw_write_guard`

## Requirements
- R1: After reset the register reads {00, 0, strap, RCFG_RST, 0, 0} (bits 7:6 reserved, bit 5 management-only, bit 4 top-swap, bits 3:2 read-config, bit 1 lock, bit 0 write-enable). Both the interrupt request and the write permit are low.
- R2: Bit 0 (write-enable) takes the written value on every write to the register offset, whether it is 0 or 1.
- R3: Bit 1 (lock) is set by writing 1 and stays 1 until reset. Writes of 0 leave it unchanged.
- R4: Bit 5 (management-only) is set by writing 1 and stays 1 until reset. Writes of 0 leave it unchanged.
- R5: If lock is already 1 before a write, and that write changes write-enable from 0 to 1, the interrupt request is high for exactly the one cycle after the write edge. The write-enable bit is still set by that write.
- R6: No interrupt request is raised in three cases: write-enable was already 1, lock was 0 before the write, or lock is being set by the same write.
- R7: The write permit equals write-enable AND (NOT management-only OR management access). It follows the management-access input combinationally.
- R8: Bit 4 always reads the strap input and ignores writes. Bits 7:6 always read 0.
- R9: Writes to any other offset change nothing, and reads at any other offset return 0.
- R10: Bits 3:2 are freely writable and reset to the parameter RCFG_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W | Configuration offset for reads and writes |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, combinational from cfg_addr |
| mgmt_access | input | 1 | Current access comes from system-management mode |
| tswap_strap | input | 1 | Strap value shown in bit 4 |
| wr_permit | output | 1 | Effective write permission for the firmware region |
| mgmt_irq | output | 1 | One-cycle management interrupt request |

## Verification
A single write can set the lock bit and raise write-enable at the same time. The rule is that a lock set in a write only takes effect for later writes. The bench provokes this by writing every one of the 256 byte values straight after reset, including 0x03. It then runs a follow-up write sequence in which, with lock already set, write-enable is cleared and then raised again. For each write, the bench compares the read-back byte, the presence or absence of the pulse, and the permit under both values of management access against its own bit-level model. In the locked case the bit changes and the interrupt pulse appears on the same edge, and the permit rises in that same cycle.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
    localparam int DATA_W  = 8;
    localparam int RCFG_W  = 2;
    localparam int B_WREN  = 0;
    localparam int B_LOCK  = 1;
    localparam int B_RCFG  = 2;
    localparam int B_TSWAP = B_RCFG + RCFG_W;
    localparam int B_MGMT  = B_TSWAP + 1;
    localparam int RSV_W   = DATA_W - B_MGMT - 1;

    typedef struct packed {
        logic              mgmt_only;
        logic [RCFG_W-1:0] rcfg;
        logic              lock;
        logic              wren;
    } ctl_t;
endpackage

// File: rtl/fwg_regs.sv
module fwg_regs
    import fwg_pkg::*;
#(
    parameter logic [RCFG_W-1:0] RCFG_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl_q
);
    ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit) begin
            ctl_d.wren      = wdata[B_WREN];
            ctl_d.lock      = ctl_q.lock | wdata[B_LOCK];
            ctl_d.rcfg      = wdata[B_RCFG +: RCFG_W];
            ctl_d.mgmt_only = ctl_q.mgmt_only | wdata[B_MGMT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.wren      <= 1'b0;
            ctl_q.lock      <= 1'b0;
            ctl_q.rcfg      <= RCFG_RST;
            ctl_q.mgmt_only <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R3: lock never falls while out of reset
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.lock |=> ctl_q.lock);
    // R4: management-only bit never falls while out of reset
    p_mgmt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.mgmt_only |=> ctl_q.mgmt_only);
    // R2: write-enable follows the written bit
    p_wren_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ctl_q.wren == $past(wdata[B_WREN]));
endmodule

// File: rtl/fwg_trap.sv
module fwg_trap (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic new_wren,
    input  logic wren_q,
    input  logic lock_q,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = wr_hit & new_wren & ~wren_q & lock_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R5: request lasts one cycle
    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R5: a request implies the bit was set while locked
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (lock_q && wren_q));
    // R6: a request needs a prior lock and a cleared enable
    p_irq_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(lock_q) && !$past(wren_q));
endmodule

// File: rtl/fwg_permit.sv
module fwg_permit (
    input  logic wren,
    input  logic mgmt_only,
    input  logic mgmt_access,
    output logic permit
);
    always_comb begin
        permit = wren & (~mgmt_only | mgmt_access);
    end
endmodule

// File: rtl/fw_write_guard.sv
module fw_write_guard
    import fwg_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'hDC,
    parameter logic [RCFG_W-1:0] RCFG_RST   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              mgmt_access,
    input  logic              tswap_strap,
    output logic              wr_permit,
    output logic              mgmt_irq
);
    logic hit, wr_hit;
    ctl_t ctl_q;

    assign hit    = (cfg_addr == REG_OFFSET);
    assign wr_hit = cfg_wr & hit;

    fwg_regs #(.RCFG_RST(RCFG_RST)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(wr_hit),
        .wdata (cfg_wdata),
        .ctl_q (ctl_q)
    );

    fwg_trap trap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .new_wren(cfg_wdata[B_WREN]),
        .wren_q  (ctl_q.wren),
        .lock_q  (ctl_q.lock),
        .irq     (mgmt_irq)
    );

    fwg_permit permit_i (
        .wren       (ctl_q.wren),
        .mgmt_only  (ctl_q.mgmt_only),
        .mgmt_access(mgmt_access),
        .permit     (wr_permit)
    );

    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            cfg_rdata[B_WREN]               = ctl_q.wren;
            cfg_rdata[B_LOCK]               = ctl_q.lock;
            cfg_rdata[B_RCFG +: RCFG_W]     = ctl_q.rcfg;
            cfg_rdata[B_TSWAP]              = tswap_strap;
            cfg_rdata[B_MGMT]               = ctl_q.mgmt_only;
            cfg_rdata[DATA_W-1 -: RSV_W]    = '0;
        end
    end

    // R7: protected region closed to non-management accesses
    p_mgmt_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mgmt_only && !mgmt_access) |-> !wr_permit);
    // R8: reserved bits stay zero
    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DATA_W-1 -: RSV_W] == '0);
    // R9: other offsets read as zero
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> cfg_rdata == '0);
endmodule

// File: tb/fw_write_guard_tb_top.sv
`timescale 1ns/1ps
module fw_write_guard_tb_top;
    localparam logic [7:0] OFF  = 8'hDC;
    localparam logic [1:0] RRST = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_addr = OFF;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       mgmt_access = 1'b0;
    logic       tswap_strap = 1'b0;
    logic       wr_permit;
    logic       mgmt_irq;

    int checks = 0;
    int errors = 0;

    logic       m_we, m_lock, m_mo, m_irq;
    logic [1:0] m_rc;

    always #5 clk = ~clk;

    fw_write_guard #(.ADDR_W(8), .REG_OFFSET(OFF), .RCFG_RST(RRST)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mgmt_access(mgmt_access),
        .tswap_strap(tswap_strap), .wr_permit(wr_permit), .mgmt_irq(mgmt_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        return {2'b00, m_mo, tswap_strap, m_rc, m_lock, m_we};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_wr = 1'b0;
        cfg_addr = OFF;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_we = 0; m_lock = 0; m_mo = 0; m_rc = RRST; m_irq = 0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        cfg_addr = a;
        cfg_wdata = d;
        cfg_wr = 1'b1;
        if (a == OFF) begin
            m_irq  = d[0] & ~m_we & m_lock;
            m_we   = d[0];
            m_lock = m_lock | d[1];
            m_rc   = d[3:2];
            m_mo   = m_mo | d[5];
        end else begin
            m_irq = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_addr = OFF;
    endtask

    task automatic check_state(input string tag);
        #1;
        check({tag, " R5 R6 irq"}, {7'd0, mgmt_irq}, {7'd0, m_irq});
        check({tag, " R2 R3 R4 R8 R10 rdata"}, cfg_rdata, exp_rd());
        mgmt_access = 1'b0;
        #1;
        check({tag, " R7 permit non-mgmt"}, {7'd0, wr_permit}, {7'd0, m_we & ~m_mo});
        mgmt_access = 1'b1;
        #1;
        check({tag, " R7 permit mgmt"}, {7'd0, wr_permit}, {7'd0, m_we});
        mgmt_access = 1'b0;
        @(negedge clk);
        check({tag, " R5 pulse ends"}, {7'd0, mgmt_irq}, 8'd0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] seq [8];
        seq = '{8'h00, 8'h01, 8'h01, 8'h00, 8'h02, 8'h01, 8'h20, 8'h00};
        for (int v = 0; v < 256; v++) begin
            tswap_strap = v[0] ^ v[4];
            do_reset();
            #1;
            check("R1 R10 reset rdata", cfg_rdata, exp_rd());
            check("R1 reset irq", {7'd0, mgmt_irq}, 8'd0);
            mgmt_access = 1'b1;
            #1;
            check("R1 reset permit", {7'd0, wr_permit}, 8'd0);
            mgmt_access = 1'b0;
            @(negedge clk);
            do_write(OFF, v[7:0]);
            check_state("first");
            for (int i = 0; i < 8; i++) begin
                do_write(OFF, seq[i] ^ (v[7:0] & 8'h0C));
                check_state("seq");
            end
            tswap_strap = ~tswap_strap;
            do_write(OFF ^ 8'h01, 8'hFF);
            #1;
            check("R9 other-offset write ignored", cfg_rdata, exp_rd());
            check("R9 no irq from other offset", {7'd0, mgmt_irq}, 8'd0);
            cfg_addr = OFF ^ 8'h01;
            #1;
            check("R9 other-offset read", cfg_rdata, 8'h00);
            cfg_addr = OFF;
            @(negedge clk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule